// File: doc/BRIEF.md
# Bit-Serial Column Overlap Scorer

This block scores a pool of minicolumns against a binary input space, one bit per clock. For every column in turn it receives a stream of input-space bits paired with that column's connection-map bits. It counts the positions where both bits are set. Once the programmed number of bits has been seen, it writes the count to a result memory at that column's address. It then starts again from zero for the next column.

Software or a sequencer loads three settings with a start pulse: the input-space size in bits, the number of columns, and the result address of the first column. The block then consumes qualified bit pairs. Each time a column finishes, it issues one write on its result port. After the last column it raises a one-cycle completion pulse and returns to idle.

Top module: `overlap_scorer`

## Requirements
- R1: After reset, wr_en, done and busy are low.
- R2: A start pulse while idle with nonzero cfg_bits and nonzero cfg_cols is accepted, and busy is high from the next cycle. A start while busy has no effect on the addresses or the number of writes of the running job. A start with cfg_bits or cfg_cols equal to zero is not accepted and busy stays low.
- R3: Each column's score equals the number of qualified bit pairs, out of that column's cfg_bits pairs, in which in_bit and map_bit are both 1.
- R4: A cycle with bit_valid low does not advance the bit position or the score. Bit pairs presented while idle produce no write and do not make busy high.
- R5: In the cycle after a column's cfg_bits-th qualified pair is taken, wr_en is high for one cycle. For the k-th column (k counted from 0), wr_addr equals cfg_base + k and wr_data equals that column's score.
- R6: Every column is scored from zero, independently of the columns before it, and consecutive columns follow without idle cycles.
- R7: done is high for exactly one cycle, in the cycle right after the write of the last column. busy is low from that cycle on.
- R8: The score can reach the full configured size, up to MAX_BITS, without wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Starts a job with the cfg_* values |
| cfg_bits | input | $clog2(MAX_BITS+1) | Input-space size in bits per column |
| cfg_cols | input | $clog2(MAX_COLS+1) | Number of columns to score |
| cfg_base | input | ADDR_W | Result address of the first column |
| bit_valid | input | 1 | Qualifies in_bit and map_bit |
| in_bit | input | 1 | Current input-space bit |
| map_bit | input | 1 | Current connection-map bit of the active column |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | ADDR_W | Result write address |
| wr_data | output | $clog2(MAX_BITS+1) | Column score |
| busy | output | 1 | A job is running |
| done | output | 1 | One-cycle completion pulse |

## Verification
Jobs with both bits always set check that the score reaches the full size, including the largest size, without wrapping. Jobs with an all-zero map separate a true AND from a count of input ones alone. A size of one writes on every qualified cycle, which exposes any off-by-one in the wrap point. Random jobs with random bit_valid gaps check both the count and the stall behaviour. Further directed runs start a job while another is running, offer bits while idle, and give zero settings, to show that these are ignored at the result port.

// File: rtl/overlap_pkg.sv
package overlap_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_RUN   = 2'd1,
        SEQ_FLUSH = 2'd2
    } seq_state_e;
endpackage

// File: rtl/bit_match_counter.sv
module bit_match_counter #(
    parameter int SIZE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SIZE_W-1:0] load_size,
    input  logic              step,
    input  logic              in_bit,
    input  logic              map_bit,
    output logic              wrap,
    output logic [SIZE_W-1:0] score_out,
    output logic [SIZE_W-1:0] size_out
);
    typedef struct packed {
        logic [SIZE_W-1:0] size;
        logic [SIZE_W-1:0] idx;
        logic [SIZE_W-1:0] acc;
    } cnt_t;

    cnt_t cnt_q, cnt_d;
    logic [SIZE_W-1:0] idx_inc;
    logic [SIZE_W-1:0] acc_inc;

    always_comb begin
        cnt_d   = cnt_q;
        idx_inc = cnt_q.idx + SIZE_W'(1);
        acc_inc = cnt_q.acc + SIZE_W'(in_bit & map_bit);
        wrap    = step && (idx_inc == cnt_q.size);
        if (load) begin
            cnt_d.size = load_size;
            cnt_d.idx  = '0;
            cnt_d.acc  = '0;
        end else if (step) begin
            if (wrap) begin
                cnt_d.idx = '0;
                cnt_d.acc = '0;
            end else begin
                cnt_d.idx = idx_inc;
                cnt_d.acc = acc_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign score_out = acc_inc;
    assign size_out  = cnt_q.size;

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q.acc <= cnt_q.idx);

    assert_index_below_size_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q.size != '0) |-> (cnt_q.idx < cnt_q.size));

    assert_stall_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> ($stable(cnt_q.acc) && $stable(cnt_q.idx)));
endmodule

// File: rtl/column_sequencer.sv
module column_sequencer
    import overlap_pkg::*;
#(
    parameter int COLS_W = 9,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              size_nz,
    input  logic [COLS_W-1:0] cfg_cols,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              wrap,
    output logic              load,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] col_addr
);
    typedef struct packed {
        seq_state_e        state;
        logic [COLS_W-1:0] cols;
        logic [COLS_W-1:0] col;
        logic [ADDR_W-1:0] addr;
        logic              done;
    } seq_t;

    seq_t seq_q, seq_d;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = (seq_q.state == SEQ_FLUSH);
        load       = 1'b0;
        unique case (seq_q.state)
            SEQ_IDLE: begin
                if (start && size_nz && (cfg_cols != '0)) begin
                    load        = 1'b1;
                    seq_d.state = SEQ_RUN;
                    seq_d.cols  = cfg_cols;
                    seq_d.col   = '0;
                    seq_d.addr  = cfg_base;
                end
            end
            SEQ_RUN: begin
                if (wrap) begin
                    if (seq_q.col == seq_q.cols - COLS_W'(1)) begin
                        seq_d.state = SEQ_FLUSH;
                    end else begin
                        seq_d.col  = seq_q.col + COLS_W'(1);
                        seq_d.addr = seq_q.addr + ADDR_W'(1);
                    end
                end
            end
            SEQ_FLUSH: seq_d.state = SEQ_IDLE;
            default:   seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.state <= SEQ_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign run      = (seq_q.state == SEQ_RUN);
    assign busy     = (seq_q.state != SEQ_IDLE);
    assign done     = seq_q.done;
    assign col_addr = seq_q.addr;

    assert_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && seq_q.state != SEQ_IDLE) |=> $stable(seq_q.cols));

    assert_col_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.state == SEQ_RUN) |-> (seq_q.col < seq_q.cols));
endmodule

// File: rtl/result_writer.sv
module result_writer #(
    parameter int ADDR_W = 10,
    parameter int SIZE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wrap,
    input  logic [ADDR_W-1:0] col_addr,
    input  logic [SIZE_W-1:0] score,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SIZE_W-1:0] wr_data
);
    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [SIZE_W-1:0] data;
    } wr_t;

    wr_t wr_q, wr_d;

    always_comb begin
        wr_d    = wr_q;
        wr_d.en = wrap;
        if (wrap) begin
            wr_d.addr = col_addr;
            wr_d.data = score;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wr_q <= '0;
        else        wr_q <= wr_d;
    end

    assign wr_en   = wr_q.en;
    assign wr_addr = wr_q.addr;
    assign wr_data = wr_q.data;
endmodule

// File: rtl/overlap_scorer.sv
module overlap_scorer #(
    parameter int MAX_BITS = 1024,
    parameter int MAX_COLS = 256,
    parameter int ADDR_W   = 10,
    localparam int SIZE_W  = $clog2(MAX_BITS + 1),
    localparam int COLS_W  = $clog2(MAX_COLS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [SIZE_W-1:0] cfg_bits,
    input  logic [COLS_W-1:0] cfg_cols,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              bit_valid,
    input  logic              in_bit,
    input  logic              map_bit,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [SIZE_W-1:0] wr_data,
    output logic              busy,
    output logic              done
);
    logic              load;
    logic              run;
    logic              step;
    logic              wrap;
    logic [SIZE_W-1:0] score;
    logic [SIZE_W-1:0] size_cur;
    logic [ADDR_W-1:0] col_addr;

    assign step = bit_valid && run;

    bit_match_counter #(.SIZE_W(SIZE_W)) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_size (cfg_bits),
        .step      (step),
        .in_bit    (in_bit),
        .map_bit   (map_bit),
        .wrap      (wrap),
        .score_out (score),
        .size_out  (size_cur)
    );

    column_sequencer #(.COLS_W(COLS_W), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .size_nz  (cfg_bits != '0),
        .cfg_cols (cfg_cols),
        .cfg_base (cfg_base),
        .wrap     (wrap),
        .load     (load),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .col_addr (col_addr)
    );

    result_writer #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .wrap     (wrap),
        .col_addr (col_addr),
        .score    (score),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    assert_done_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(wr_en));

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_score_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_data <= size_cur));

    assert_no_write_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done) |=> !wr_en);
endmodule

// File: tb/overlap_scorer_bench.sv
module overlap_scorer_bench;
    localparam int MAXB = 64;
    localparam int MAXC = 16;
    localparam int AW   = 8;
    localparam int SW   = $clog2(MAXB + 1);
    localparam int CW   = $clog2(MAXC + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [SW-1:0] cfg_bits = '0;
    logic [CW-1:0] cfg_cols = '0;
    logic [AW-1:0] cfg_base = '0;
    logic bit_valid = 1'b0, in_bit = 1'b0, map_bit = 1'b0;
    logic wr_en, busy, done;
    logic [AW-1:0] wr_addr;
    logic [SW-1:0] wr_data;

    always #2 clk = ~clk;

    overlap_scorer #(.MAX_BITS(MAXB), .MAX_COLS(MAXC), .ADDR_W(AW)) u_overlap_scorer (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_bits(cfg_bits),
        .cfg_cols(cfg_cols), .cfg_base(cfg_base), .bit_valid(bit_valid),
        .in_bit(in_bit), .map_bit(map_bit), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .busy(busy), .done(done)
    );

    int n_chk = 0, n_fail = 0, done_cnt = 0;
    int exp_addr[$];
    int exp_data[$];
    bit mon_on = 1'b0;
    bit prev_wr = 1'b0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic int andbit(input bit a, input bit b);
        return (a && b) ? 1 : 0;
    endfunction

    // Result-port monitor: R5 write content, R7 completion timing
    always @(negedge clk) begin
        if (mon_on) begin
            if (wr_en) begin
                if (exp_addr.size() == 0) begin
                    chk(1'b0, "R5 unexpected write addr", int'(wr_addr), -1);
                end else begin
                    int ea, ed;
                    ea = exp_addr.pop_front();
                    ed = exp_data.pop_front();
                    chk(int'(wr_addr) == ea, "R5 write address", int'(wr_addr), ea);
                    chk(int'(wr_data) == ed, "R3 score", int'(wr_data), ed);
                end
            end
            if (done) begin
                done_cnt++;
                chk(prev_wr, "R7 done follows last write", int'(prev_wr), 1);
                chk(!busy, "R7 busy low with done", int'(busy), 0);
            end
            prev_wr = wr_en;
        end
    end

    // mode 0 random, 1 all ones, 2 zero map; gaps inserts stalls; restart pulses start mid-job
    task automatic run_job(input int base, input int cols, input int size,
                           input int mode, input bit gaps, input bit restart);
        bit invec[MAXB];
        int d0;
        d0 = done_cnt;
        for (int i = 0; i < MAXB; i++) invec[i] = 1'($urandom);
        @(negedge clk);
        start = 1'b1; cfg_base = AW'(base); cfg_cols = CW'(cols); cfg_bits = SW'(size);
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R2 busy after start", int'(busy), 1);
        for (int c = 0; c < cols; c++) begin
            int score = 0;
            for (int b = 0; b < size; b++) begin
                while (gaps && ($urandom % 3 == 0)) begin
                    bit_valid = 1'b0; in_bit = 1'b1; map_bit = 1'b1;
                    @(negedge clk);
                end
                bit_valid = 1'b1;
                case (mode)
                    1: begin in_bit = 1'b1; map_bit = 1'b1; end
                    2: begin in_bit = invec[b]; map_bit = 1'b0; end
                    default: begin in_bit = invec[b]; map_bit = 1'($urandom); end
                endcase
                score += andbit(in_bit, map_bit);
                start = (restart && c == 0 && b == 0);
                cfg_base = AW'(base + 100);
                if (b == size - 1) begin
                    exp_addr.push_back((base + c) % 256);
                    exp_data.push_back(score);
                end
                @(negedge clk);
                start = 1'b0;
            end
        end
        bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(done_cnt == d0 + 1, "R7 one done per job", done_cnt - d0, 1);
        chk(exp_addr.size() == 0, "R6 all columns written", exp_addr.size(), 0);
        chk(!busy, "R7 idle after job", int'(busy), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(!wr_en, "R1 wr_en reset", int'(wr_en), 0);
        chk(!done, "R1 done reset", int'(done), 0);
        chk(!busy, "R1 busy reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        mon_on = 1'b1;

        // R4: bits while idle ignored
        for (int i = 0; i < 8; i++) begin
            bit_valid = 1'b1; in_bit = 1'b1; map_bit = 1'b1;
            @(negedge clk);
            chk(!busy && !wr_en, "R4 idle bits ignored", int'(busy | wr_en), 0);
        end
        bit_valid = 1'b0;

        // R2: zero settings rejected
        start = 1'b1; cfg_cols = '0; cfg_bits = SW'(5);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy, "R2 zero column count rejected", int'(busy), 0);
        start = 1'b1; cfg_cols = CW'(3); cfg_bits = '0;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        chk(!busy, "R2 zero size rejected", int'(busy), 0);

        run_job(0, 4, 1, 1, 1'b0, 1'b0);   // R5/R6 size one, back-to-back writes
        run_job(10, 2, MAXB, 1, 1'b0, 1'b0); // R8 full score at max size
        run_job(40, 3, 20, 2, 1'b1, 1'b0); // R3 zero map gives zero
        run_job(60, 1, 17, 0, 1'b0, 1'b0); // single column
        run_job(90, 5, 9, 0, 1'b1, 1'b1);  // R2 start while busy ignored
        for (int j = 0; j < 20; j++) begin  // R3/R4 random with stalls
            run_job(int'($urandom % 200), 1 + int'($urandom % MAXC),
                    1 + int'($urandom % MAXB), 0, 1'($urandom), 1'b0);
        end
        run_job(200, MAXC, 3, 0, 1'b1, 1'b0); // max column count

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule